// File: doc/BRIEF.md
# Priority-Chained Bus Grant Controller for Direct Memory Access

This block lets peripheral devices take over the shared system bus for direct memory access. Any device on the chain can raise its request. The processor-side controller waits until the processor's own bus cycle has ended, with its cycle strobe low, and then drives a bus grant. The grant enters the first chain cell and ripples through the cells in fixed positional order. Position 0 sits nearest the processor and has the highest priority.

A cell whose device has no request passes the grant on unchanged. A cell whose device is requesting stops the grant. On the next clock edge it raises that device's selection acknowledge. The controller sees the acknowledge, withdraws the grant and holds the processor off the bus. It keeps that hold until the acknowledge is gone. The acknowledging device then moves data on its own until it drops its request, and that drop releases the acknowledge.

The controller also guards against a second acknowledge. While any acknowledge is present on the bus, no other cell can capture the grant, even one that sees a grant still on its input.

Top module: `dma_grant_chain`

## Requirements
- R1: While `rst_n` is low and after its release, `dmgo_o`, `cpu_hold_o`, `sack_o`, every bit of `dev_sack_o` and every bit of `dev_grant_o` are 0.
- R2: `dmr_o` is the OR of all bits of `dev_req_i`, with no clock delay.
- R3: The grant rises only at a bus-cycle boundary. When the controller is idle, `dmr_o` is 1 and `cpu_sync_i` is 0 at a clock edge, `dmgo_o` and `cpu_hold_o` are 1 after that edge. While `cpu_sync_i` is 1 the grant stays 0.
- R4: `dev_grant_o[0]` equals `dmgo_o`. For each position i, `dev_grant_o[i+1]` equals `dev_grant_o[i]` whenever device i neither requests nor holds an acknowledge.
- R5: Bit i of `dev_sack_o` is set at the first clock edge where device i sees a grant, requests, and no acknowledge is on the bus. A requesting device blocks the grant to all positions above it, so the lowest-index requester wins.
- R6: At most one bit of `dev_sack_o` is 1 at any time. A device that starts requesting while another device holds the acknowledge does not capture, even if the grant is still present.
- R7: `dmgo_o` falls at the first clock edge at which `sack_o` is 1.
- R8: `cpu_hold_o` stays 1 from the grant edge through the ownership period. It falls at the first edge after `sack_o` has returned to 0.
- R9: An acknowledging device's `dev_sack_o` bit clears at the first clock edge where its request is 0.
- R10: If every request is withdrawn while the grant is out and before any capture, `dmgo_o` and `cpu_hold_o` fall at the next edge.

Ports (`N_DEV` = number of chain positions):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sync_i | input | 1 | Processor bus cycle in progress |
| dev_req_i | input | N_DEV | Per-device bus request, bit 0 highest priority |
| dmr_o | output | 1 | Combined bus request seen by the processor |
| dmgo_o | output | 1 | Bus grant driven into chain position 0 |
| cpu_hold_o | output | 1 | Processor must not start a new bus cycle |
| dev_grant_o | output | N_DEV | Grant arriving at each chain position |
| dev_sack_o | output | N_DEV | Per-device selection acknowledge |
| sack_o | output | 1 | Combined acknowledge on the bus |

## Verification
Two events can land in the same clock cycle. In the first, a higher-priority device starts requesting in the one cycle where a lower-priority device has just captured the acknowledge but the grant has not yet fallen. The bench raises that request right after the capture edge and requires that the acknowledge vector stay unchanged across the next edge. In the second, the acknowledge releases at the same moment other devices keep requesting. The bench requires one idle cycle followed by a fresh grant that reaches the highest-priority remaining requester. A third case raises a request in the cycle the processor strobe falls, and the bench checks that the grant appears exactly one edge later.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
   typedef enum logic [1:0] {
      GS_IDLE  = 2'd0,
      GS_GRANT = 2'd1,
      GS_OWNED = 2'd2
   } gnt_state_e;
endpackage

// File: rtl/dgc_grant_fsm.sv
module dgc_grant_fsm
   import dgc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_sync_i,
   input  logic dmr_i,
   input  logic sack_i,
   output logic dmgo_o,
   output logic hold_o
);
   gnt_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GS_IDLE:  if (dmr_i && !cpu_sync_i) state_d = GS_GRANT;
         GS_GRANT: begin
            if (sack_i)      state_d = GS_OWNED;
            else if (!dmr_i) state_d = GS_IDLE;
         end
         GS_OWNED: if (!sack_i) state_d = GS_IDLE;
         default:  state_d = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= GS_IDLE;
      else        state_q <= state_d;
   end

   assign dmgo_o = (state_q == GS_GRANT);
   assign hold_o = (state_q != GS_IDLE);

   // R3: grant only appears after a cycle with no processor strobe
   p_grant_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dmgo_o) |-> $past(!cpu_sync_i));
   // R7: an acknowledge withdraws the grant at the next edge
   p_grant_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dmgo_o && sack_i) |=> !dmgo_o);
   // R8: processor stays held while any acknowledge is present
   p_hold_sack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sack_i |-> hold_o);
endmodule

// File: rtl/dgc_chain_cell.sv
module dgc_chain_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_in_i,
   input  logic req_i,
   input  logic bus_sack_i,
   output logic grant_out_o,
   output logic sack_o
);
   logic sack_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      sack_q <= 1'b0;
      else if (sack_q) sack_q <= req_i;
      else             sack_q <= grant_in_i && req_i && !bus_sack_i;
   end

   assign grant_out_o = grant_in_i && !req_i && !sack_q;
   assign sack_o      = sack_q;

   // R5: capture requires a grant and a request in the cycle before
   p_capture_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sack_q) |-> $past(grant_in_i && req_i));
   // R9: dropping the request releases the acknowledge
   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sack_q && !req_i) |=> !sack_q);
endmodule

// File: rtl/dma_grant_chain.sv
module dma_grant_chain #(
   parameter int N_DEV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_sync_i,
   input  logic [N_DEV-1:0] dev_req_i,
   output logic             dmr_o,
   output logic             dmgo_o,
   output logic             cpu_hold_o,
   output logic [N_DEV-1:0] dev_grant_o,
   output logic [N_DEV-1:0] dev_sack_o,
   output logic             sack_o
);
   localparam int CHAIN_LEN = N_DEV + 1;

   generate
      if (N_DEV < 1 || N_DEV > 256) begin : g_bad_ndev
         $error("dma_grant_chain: N_DEV out of range 1..256");
      end
   endgenerate

   logic [CHAIN_LEN-1:0] chain;
   logic                 bus_sack;

   assign dmr_o    = |dev_req_i;
   assign bus_sack = |dev_sack_o;
   assign sack_o   = bus_sack;

   dgc_grant_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_sync_i (cpu_sync_i),
      .dmr_i      (dmr_o),
      .sack_i     (bus_sack),
      .dmgo_o     (dmgo_o),
      .hold_o     (cpu_hold_o)
   );

   assign chain[0] = dmgo_o;

   generate
      for (genvar i = 0; i < N_DEV; i++) begin : g_cell
         dgc_chain_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant_in_i  (chain[i]),
            .req_i       (dev_req_i[i]),
            .bus_sack_i  (bus_sack),
            .grant_out_o (chain[i+1]),
            .sack_o      (dev_sack_o[i])
         );
         assign dev_grant_o[i] = chain[i];
      end
   endgenerate

   logic unused_tail;
   assign unused_tail = chain[N_DEV];

   // R6: never two acknowledges at once
   p_one_sack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sack_o));
   // R1: nothing is granted or acknowledged in the cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!dmgo_o && !bus_sack));
endmodule

// File: tb/dma_grant_chain_tb_top.sv
module dma_grant_chain_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sync = 1'b0;
   logic [N-1:0] req = '0;
   logic         dmr, dmgo, hold, sack;
   logic [N-1:0] grant, sackv;

   always #2 clk = ~clk;

   dma_grant_chain #(.N_DEV(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sync_i(sync), .dev_req_i(req),
      .dmr_o(dmr), .dmgo_o(dmgo), .cpu_hold_o(hold),
      .dev_grant_o(grant), .dev_sack_o(sackv), .sack_o(sack)
   );

   typedef struct {
      string      tag;
      int         kind;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 0;

   function automatic logic [7:0] sample(int kind);
      case (kind)
         0: return {7'd0, dmgo};
         1: return {7'd0, hold};
         2: return {7'd0, dmr};
         3: return {4'd0, sackv};
         4: return {4'd0, grant};
         default: return {7'd0, sack};
      endcase
   endfunction

   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = sample(it.kind);
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%b expected=%b", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(string tag, int kind, logic [7:0] e);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = e;
      q.push_back(it);
      ->chk_ev;
      #0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      expect_v("R1 reset dmgo", 0, 0);
      expect_v("R1 reset hold", 1, 0);
      expect_v("R1 reset sack", 3, 0);
      expect_v("R1 reset grant", 4, 0);
      rst_n = 1'b1;
      step();
      expect_v("R1 after reset dmgo", 0, 0);
      expect_v("R1 after reset sack_o", 5, 0);

      // Processor busy: request must wait
      sync = 1'b1; req = 4'b0001;
      settle();
      expect_v("R2 dmr follows req", 2, 1);
      step();
      expect_v("R3 no grant during sync", 0, 0);
      step();
      expect_v("R3 still no grant", 0, 0);
      expect_v("R8 no hold while idle", 1, 0);
      sync = 1'b0;
      step();
      expect_v("R3 grant at boundary", 0, 1);
      expect_v("R8 hold with grant", 1, 1);
      expect_v("R4 grant into pos0", 4, 8'b0001);
      step();
      expect_v("R5 dev0 captures", 3, 8'b0001);
      expect_v("R5 downstream blocked", 4, 8'b0001);
      step();
      expect_v("R7 grant dropped", 0, 0);
      expect_v("R8 hold in ownership", 1, 1);
      req = 4'b0000;
      settle();
      expect_v("R2 dmr clears", 2, 0);
      step();
      expect_v("R9 sack released", 3, 0);
      expect_v("R8 hold one more cycle", 1, 1);
      step();
      expect_v("R8 hold released", 1, 0);

      // Request and strobe release in the same cycle, mid-chain device
      sync = 1'b1;
      step();
      sync = 1'b0; req = 4'b0100;
      step();
      expect_v("R3 grant one edge after strobe falls", 0, 1);
      expect_v("R4 pass-through to pos2", 4, 8'b0111);
      step();
      expect_v("R5 dev2 captures", 3, 8'b0100);
      step();
      req = 4'b0000;
      step(); step();
      expect_v("R8 idle after dev2", 1, 0);

      // Two requesters, late high-priority request in capture window
      req = 4'b1010;
      step();
      expect_v("R4 grant stops at dev1", 4, 8'b0011);
      step();
      expect_v("R5 dev1 wins over dev3", 3, 8'b0010);
      req = 4'b1011;
      step();
      expect_v("R6 late request no capture", 3, 8'b0010);
      expect_v("R7 grant gone", 0, 0);
      req = 4'b1001;
      step();
      expect_v("R9 dev1 released", 3, 0);
      step();
      expect_v("R8 hold drops before regrant", 1, 0);
      expect_v("R8 no grant in idle cycle", 0, 0);
      step();
      expect_v("R3 regrant", 0, 1);
      step();
      expect_v("R5 dev0 wins regrant", 3, 8'b0001);
      req = 4'b0000;
      step();
      expect_v("R9 dev0 released", 3, 0);
      expect_v("R7 grant down", 0, 0);
      step();
      expect_v("R8 final idle", 1, 0);

      // Withdrawal before capture
      req = 4'b1000;
      step();
      expect_v("R10 grant issued", 0, 1);
      req = 4'b0000;
      step();
      expect_v("R10 grant withdrawn", 0, 0);
      expect_v("R10 hold withdrawn", 1, 0);
      expect_v("R10 no capture", 3, 0);

      step();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule